// File: doc/BRIEF.md
# Shared Resource Call Arbiter

This block puts one compute resource behind several call sites. Each call site drives its own call strobe and its own argument word. Each call site receives its own completion strobe. All call sites read one shared result bus. A call site starts a call by holding its argument on its argument input and pulsing its call strobe for one cycle. It keeps the argument stable until its completion strobe arrives.

Each call site is configured at elaboration time as either arbitrated or plain-multiplexed.
- **Arbitrated sites:** a call is latched as pending. It waits for a round-robin grant, which always adds one admission cycle.
- **Plain-multiplexed sites:** the integrator guarantees these never collide with any other call. Their call is steered straight onto the resource in the same cycle.
- **No arbitrated sites:** if no site is marked arbitrated, the arbiter is not built at all.

A lock records which site owns the resource from acceptance until completion. The completion strobe therefore goes only to the caller that was served.

The wrapped resource is a stub with a latency that depends on the data:
- Result: `3*arg + 1`, taken modulo 2^DATA_W.
- Latency: `MIN_LAT + arg[LAT_BITS-1:0]` cycles.

The variable latency makes contention and back-to-back hand-over observable.

Top module: `shared_call_arbiter`

## Requirements
- R1: After reset deasserts, `done_o` is all zero. No completion appears until a call is made.
- R2: Suppose a plain-multiplexed site pulses `call_i` in cycle c while the resource is free. Then its `done_o` bit pulses in cycle c+L, where L = MIN_LAT + arg[1:0] (MIN_LAT=1 by default). In that same cycle `result_o` equals (3*arg+1) mod 2^16.
- R3: Suppose an arbitrated site (sites 0 and 1 by default, `ARB_MASK` bit set) pulses `call_i` in cycle c while the resource is idle. Then its `done_o` bit pulses in cycle c+1+L, with the same result.
- R4: `done_o` has at most one bit set. The set bit is the served site's bit, and it is high for one cycle per call.
- R5: While a call is in progress, no other call is accepted. Calls made together complete one after another, each with its own correct result.
- R6: Pending arbitrated calls are granted round-robin, starting from the site after the last one granted. After reset the search starts at site 0.
- R7: An arbitrated call that arrives while the resource is busy stays pending until it is granted, and it is then served.
- R8: When one call completes and another call is waiting, the waiting call is accepted at the end of the completion cycle. Its `done_o` pulse follows exactly L cycles after the previous completion.
- R9: Suppose a plain-multiplexed call and a pending arbitrated call compete for the same free cycle. The plain-multiplexed call is accepted, and the arbitrated call waits for the next free cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | N_SITES | One-cycle call strobe per call site |
| arg_i | input | N_SITES*DATA_W | Argument word per call site, site k at bits [k*DATA_W +: DATA_W] |
| done_o | output | N_SITES | One-cycle completion strobe, only for the served site |
| result_o | output | DATA_W | Shared result bus, valid while any `done_o` bit is high |

## Verification
Two events can fall in the same cycle: the completion of one call, and the acceptance of the next call through the lock.

The bench provokes this in two ways:
- It keeps an arbitrated call pending behind a running call, so that the grant lands on the completion cycle.
- It fires a plain-multiplexed call exactly on the negative edge where a completion is observed, while an arbitrated call is also pending.

The bench judges each case by two things:
- The cycle count between consecutive `done_o` pulses must equal the next call's own latency.
- The plain-multiplexed caller must be the one served first.

// File: rtl/scarb_pkg.sv
`timescale 1ns/1ps
package scarb_pkg;
  typedef enum logic {
    RES_IDLE = 1'b0,
    RES_RUN  = 1'b1
  } res_state_e;
endpackage

// File: rtl/scarb_rr_arbiter.sv
`timescale 1ns/1ps
module scarb_rr_arbiter #(
  parameter int unsigned N_SITES = 4,
  parameter logic [N_SITES-1:0] ARB_MASK = '1,
  localparam int unsigned IDX_W = (N_SITES > 1) ? $clog2(N_SITES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SITES-1:0] call_i,
  input  logic               en_i,
  output logic [N_SITES-1:0] gnt_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic               gnt_vld_o
);
  logic [N_SITES-1:0] pend_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_found;

  // rotate search starting one past the last granted site
  always_comb begin
    pick_idx   = '0;
    pick_found = 1'b0;
    for (int off = 1; off <= int'(N_SITES); off++) begin
      int j;
      j = (int'(ptr_q) + off) % int'(N_SITES);
      if (!pick_found && pend_q[j]) begin
        pick_found = 1'b1;
        pick_idx   = IDX_W'(j);
      end
    end
  end

  assign gnt_vld_o = pick_found & en_i;
  assign gnt_idx_o = pick_idx;
  assign gnt_o     = gnt_vld_o ? (N_SITES'(1) << pick_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ptr_q  <= IDX_W'(N_SITES - 1);
    end else begin
      pend_q <= (pend_q & ~gnt_o) | (call_i & ARB_MASK);
      if (gnt_vld_o) ptr_q <= pick_idx;
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R7
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(pend_q & ~gnt_o)) == $past(pend_q & ~gnt_o)));
endmodule

// File: rtl/scarb_resource_stub.sv
`timescale 1ns/1ps
module scarb_resource_stub
  import scarb_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MIN_LAT  = 1,
  parameter int unsigned LAT_BITS = 2,
  localparam int unsigned MAX_LAT = MIN_LAT + (1 << LAT_BITS) - 1,
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] res_o
);
  res_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] res_q;
  logic [CNT_W-1:0]  lat_load;
  logic [DATA_W-1:0] res_calc;

  assign lat_load = CNT_W'(MIN_LAT - 1) + CNT_W'(arg_i[LAT_BITS-1:0]);
  assign res_calc = (arg_i << 1) + arg_i + DATA_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RES_IDLE;
      cnt_q   <= '0;
      res_q   <= '0;
    end else if (start_i) begin
      state_q <= RES_RUN;
      cnt_q   <= lat_load;
      res_q   <= res_calc;
    end else if (state_q == RES_RUN) begin
      if (cnt_q == '0) state_q <= RES_IDLE;
      else             cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = (state_q == RES_RUN);
  assign fin_o  = busy_o && (cnt_q == '0);
  assign res_o  = res_q;

  // R5
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!busy_o || fin_o));

  // R2
  res_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> $stable(res_o));

  // R4
  fin_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_o && !start_i) |=> !fin_o);
endmodule

// File: rtl/scarb_owner_lock.sv
`timescale 1ns/1ps
module scarb_owner_lock #(
  parameter int unsigned N_SITES = 4,
  localparam int unsigned IDX_W = (N_SITES > 1) ? $clog2(N_SITES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   start_idx_i,
  input  logic               fin_i,
  output logic [N_SITES-1:0] done_o
);
  logic [IDX_W-1:0] owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      owner_q <= '0;
    else if (start_i) owner_q <= start_idx_i;
  end

  assign done_o = fin_i ? (N_SITES'(1) << owner_q) : '0;

  // R4
  done_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

// File: rtl/shared_call_arbiter.sv
`timescale 1ns/1ps
module shared_call_arbiter #(
  parameter int unsigned N_SITES  = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MIN_LAT  = 1,
  parameter int unsigned LAT_BITS = 2,
  parameter logic [N_SITES-1:0] ARB_MASK = 4'b0011
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_SITES-1:0]          call_i,
  input  logic [N_SITES*DATA_W-1:0]   arg_i,
  output logic [N_SITES-1:0]          done_o,
  output logic [DATA_W-1:0]           result_o
);
  localparam int unsigned IDX_W = (N_SITES > 1) ? $clog2(N_SITES) : 1;

  logic [N_SITES-1:0] mux_call;
  logic               mux_any;
  logic [IDX_W-1:0]   mux_idx;
  logic               res_busy;
  logic               res_fin;
  logic               res_free;
  logic               arb_en;
  logic [N_SITES-1:0] arb_gnt;
  logic [IDX_W-1:0]   arb_idx;
  logic               arb_vld;
  logic               start;
  logic [IDX_W-1:0]   sel_idx;
  logic [DATA_W-1:0]  sel_arg;

  assign mux_call = call_i & ~ARB_MASK;
  assign mux_any  = |mux_call;

  always_comb begin
    mux_idx = '0;
    for (int k = int'(N_SITES) - 1; k >= 0; k--) begin
      if (mux_call[k]) mux_idx = IDX_W'(k);
    end
  end

  assign res_free = !res_busy || res_fin;
  // plain sites take the free slot first
  assign arb_en   = res_free && !mux_any;

  generate
    if (ARB_MASK != '0) begin : g_arb
      scarb_rr_arbiter #(
        .N_SITES (N_SITES),
        .ARB_MASK(ARB_MASK)
      ) u_arb (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .call_i   (call_i),
        .en_i     (arb_en),
        .gnt_o    (arb_gnt),
        .gnt_idx_o(arb_idx),
        .gnt_vld_o(arb_vld)
      );
    end else begin : g_no_arb
      assign arb_gnt = '0;
      assign arb_idx = '0;
      assign arb_vld = 1'b0;
    end
  endgenerate

  assign start   = (mux_any && res_free) || arb_vld;
  assign sel_idx = mux_any ? mux_idx : arb_idx;
  assign sel_arg = arg_i[sel_idx*DATA_W +: DATA_W];

  scarb_resource_stub #(
    .DATA_W  (DATA_W),
    .MIN_LAT (MIN_LAT),
    .LAT_BITS(LAT_BITS)
  ) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .arg_i  (sel_arg),
    .busy_o (res_busy),
    .fin_o  (res_fin),
    .res_o  (result_o)
  );

  scarb_owner_lock #(
    .N_SITES(N_SITES)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_idx_i(sel_idx),
    .fin_i      (res_fin),
    .done_o     (done_o)
  );

  // R2
  mux_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_any |-> res_free);

  // R2
  mux_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mux_call));

  // R9
  mux_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mux_any |-> (arb_gnt == '0));
endmodule

// File: tb/shared_call_arbiter_test.sv
`timescale 1ns/1ps
module shared_call_arbiter_test;
  localparam int NS = 4;
  localparam int DW = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NS-1:0]    call;
  logic [NS*DW-1:0] args;
  logic [NS-1:0]    done;
  logic [DW-1:0]    result;

  int checks = 0;
  int fails  = 0;

  // {site[1:0], arg[15:0]}; sites 0,1 arbitrated, 2,3 plain
  localparam logic [17:0] VEC [8] = '{
    {2'd0, 16'h0010}, {2'd2, 16'h1235}, {2'd1, 16'hFFFF}, {2'd3, 16'h0002},
    {2'd0, 16'h7A03}, {2'd2, 16'h0000}, {2'd1, 16'h4441}, {2'd3, 16'h8006}
  };

  shared_call_arbiter uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .call_i  (call),
    .arg_i   (args),
    .done_o  (done),
    .result_o(result)
  );

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] exp_res(input logic [DW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'd3 + 32'd1;
    return t[DW-1:0];
  endfunction

  function automatic int exp_lat(input logic [DW-1:0] a);
    return 1 + int'(a[1:0]);
  endfunction

  function automatic bit is_arb(input int s);
    return (s == 0) || (s == 1);
  endfunction

  task automatic set_arg(input int s, input logic [DW-1:0] a);
    args[s*DW +: DW] = a;
  endtask

  // wait n negedges; quiet before the last, then site s must complete
  task automatic expect_done(input int s, input int n, input logic [DW-1:0] a,
                             input string tag);
    logic [NS-1:0] early;
    early = '0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == 1) call = '0;
      if (i < n) early |= done;
    end
    checks++;
    if (early != '0 || done != NS'(1 << s) || result != exp_res(a)) begin
      fails++;
      $display("FAIL %s site %0d: done=%b early=%b result=%h expected done=%b result=%h",
               tag, s, done, early, result, NS'(1 << s), exp_res(a));
    end
  endtask

  initial begin
    call = '0;
    args = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and quiet
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (done != '0) begin
        fails++;
        $display("FAIL R1: done=%b expected 0", done);
      end
    end

    // R2 / R3 / R4 isolated calls from the table
    foreach (VEC[v]) begin
      int s;
      logic [DW-1:0] a;
      s = int'(VEC[v][17:16]);
      a = VEC[v][15:0];
      set_arg(s, a);
      call = NS'(1 << s);
      expect_done(s, exp_lat(a) + (is_arb(s) ? 1 : 0), a,
                  is_arb(s) ? "R3/R4 arbitrated" : "R2/R4 plain");
      repeat (2) @(negedge clk);
    end

    // R5 R6 R8: simultaneous arbitrated calls; last grant was site 1 -> site 0 first
    set_arg(0, 16'h0101);
    set_arg(1, 16'h0032);
    call = 4'b0011;
    expect_done(0, 1 + exp_lat(16'h0101), 16'h0101, "R5/R6 first");
    expect_done(1, exp_lat(16'h0032), 16'h0032, "R8 hand-over");
    repeat (2) @(negedge clk);

    // R6: pointer now at site 1 -> site 0 first again
    set_arg(0, 16'h0203);
    set_arg(1, 16'h0300);
    call = 4'b0011;
    expect_done(0, 1 + exp_lat(16'h0203), 16'h0203, "R6 rotate a");
    expect_done(1, exp_lat(16'h0300), 16'h0300, "R6 rotate a second");
    repeat (2) @(negedge clk);

    // R6: pointer at site 1 ... then call again: site 0 granted, so force order check
    set_arg(0, 16'h0001);
    call = 4'b0001;
    expect_done(0, 1 + exp_lat(16'h0001), 16'h0001, "R6 prime");
    repeat (2) @(negedge clk);
    // last grant site 0 -> site 1 served first
    set_arg(0, 16'h0A02);
    set_arg(1, 16'h0B01);
    call = 4'b0011;
    expect_done(1, 1 + exp_lat(16'h0B01), 16'h0B01, "R6 rotate b");
    expect_done(0, exp_lat(16'h0A02), 16'h0A02, "R6 rotate b second");
    repeat (2) @(negedge clk);

    // R7: arbitrated call arriving while busy stays pending
    set_arg(2, 16'h0503);
    call = 4'b0100;
    @(negedge clk);
    checks++;
    if (done != '0) begin
      fails++;
      $display("FAIL R7: done=%b expected 0", done);
    end
    set_arg(1, 16'h0602);
    call = 4'b0010;
    expect_done(2, exp_lat(16'h0503) - 1, 16'h0503, "R7 running");
    expect_done(1, exp_lat(16'h0602), 16'h0602, "R7 pending served");
    repeat (2) @(negedge clk);

    // R9: plain call in the completion cycle while arbitrated call is pending
    set_arg(3, 16'h0703);
    call = 4'b1000;
    @(negedge clk);
    set_arg(0, 16'h0811);
    call = 4'b0001;
    expect_done(3, exp_lat(16'h0703) - 1, 16'h0703, "R9 first");
    set_arg(2, 16'h0902);
    call = 4'b0100;
    expect_done(2, exp_lat(16'h0902), 16'h0902, "R9 plain wins");
    expect_done(0, exp_lat(16'h0811), 16'h0811, "R9 arbitrated after");

    // R4: nothing further after the last pulse
    repeat (6) @(negedge clk);
    checks++;
    if (done != '0) begin
      fails++;
      $display("FAIL R4: stray done=%b expected 0", done);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule